// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Coalescing Registers

This block is the software-facing control and status register set for one channel of a scatter-gather DMA engine. Software reaches it through a simple 32-bit register bus with separate read and write strobes. A read returns its data in the same cycle, and any side effect of the read takes effect at the clock edge. The block holds run, soft-reset and tail-pointer-mode controls, the halted and idle flags, and the current and tail descriptor pointers. It hands the run and idle flags, the pointers and a one-cycle start request to the datapath engine. The engine reports back through a completion strobe and a set-idle strobe.

Completion strobes are coalesced into interrupts in two ways. A packet counter counts down from a threshold and raises a completion interrupt when it reaches zero. A delay timer, clocked by a tick-enable input, raises a delay interrupt once completions stop arriving for a set number of ticks. Both live counters can be read back in the upper bytes of the status word. A single level interrupt output combines the pending interrupt bits with their enables.

Top module: `dmac_chan_ctl`

## Requirements
- R1: After the synchronous active-low reset, control (offset 0x00) reads 0x0001_0002 and status (offset 0x04) reads 0x0001_0001. The current pointer (0x08), the tail pointer (0x10), `irq` and `start_req` are all zero.
- R2: Control bit 1 (tail-pointer mode) always reads 1, whatever value is written. Other control bits read back as written. Bit 0 is run and bit 2 is soft reset.
- R3: Writing control with bit 2 set performs a soft reset. Control then reads 0x0001_0006 and status reads halted only, with pending interrupts cleared, the timer at 0 and the counter at 1. The reset bit reads back on the next control read, and that read clears it. Any control write made while the bit is still set repeats the soft reset.
- R4: A control write with bit 0 set, made while no soft reset is pending, clears the halted (status bit 0) and idle (status bit 1) flags. `run_flag` follows control bit 0.
- R5: Every control write reloads the completion counter from control bits 23:16.
- R6: Each `cmpl_evt` decrements the completion counter. When the counter goes from 1 to 0, status bit 12 is set and the counter is reloaded from control bits 23:16.
- R7: A `cmpl_evt` while control bits 31:24 are nonzero restarts the delay timer with that value. Each `tick_en` decrements the timer until it reaches zero, and it then stays at zero. The step from 1 to 0 sets status bit 13 and reloads the completion counter.
- R8: Writing ones to status bits 14:12 clears those pending bits. Zeros leave them unchanged.
- R9: `irq` is high exactly when some status bit in 14:12 is set together with the same bit of control 14:12.
- R10: A status read returns the timer in bits 31:24, the completion counter in bits 23:16, pending interrupts in bits 14:12, idle in bit 1 and halted in bit 0. All other bits read 0.
- R11: A write to the tail pointer (0x10) stores the value, clears idle and drives `start_req` high for exactly the following cycle. The current pointer (0x08) reads back as written.
- R12: `eng_set_idle` sets idle. A run write or a tail write in the same cycle takes precedence and leaves idle clear.
- R13: With a threshold of 0, a completion makes the counter wrap to 255 and raises no completion interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects apply at the edge) |
| bus_addr | input | ADDR_W | Byte offset within the channel window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, same cycle |
| cmpl_evt | input | 1 | Completion strobe from the datapath engine |
| tick_en | input | 1 | Delay-timer tick enable |
| eng_set_idle | input | 1 | Engine reports the chain is done |
| run_flag | output | 1 | Run control bit |
| idle_flag | output | 1 | Idle status flag |
| cur_desc | output | PTR_W | Current descriptor pointer |
| tail_desc | output | PTR_W | Tail descriptor pointer |
| start_req | output | 1 | One-cycle start request after a tail write |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default values, ADDR_W = 6 and PTR_W = 32. This covers the whole 0x30-byte window and the full width of the pointers, and every register can be written and read back through the bus. Because the counter and timer fields are 8 bits wide, the bench can reach the wrap of a zero threshold, the timer holding at zero and the restart of the timer with only a few dozen strobes. It also drives the same-cycle case of a set-idle strobe together with a tail write.

// File: rtl/dmac_pkg.sv
// Shared register offsets and bit positions for the DMA channel control block.
// Assumes a 32-bit data bus and byte offsets inside a 0x30-byte channel window.
package dmac_pkg;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned OFF_CTRL    = 'h00;
    localparam int unsigned OFF_STAT    = 'h04;
    localparam int unsigned OFF_CUR     = 'h08;
    localparam int unsigned OFF_TAIL    = 'h10;

    localparam int unsigned CB_RUN      = 0;
    localparam int unsigned CB_TAILMODE = 1;
    localparam int unsigned CB_SRST     = 2;
    localparam int unsigned SB_HALT     = 0;
    localparam int unsigned SB_IDLE     = 1;

    localparam int unsigned IRQ_LO      = 12;
    localparam int unsigned IRQ_N       = 3;
    localparam int unsigned FIELD_W     = 8;
    localparam int unsigned THR_LO      = 16;
    localparam int unsigned DLY_LO      = 24;

    localparam logic [DATA_W-1:0] CTRL_INIT = 32'h0001_0002;
endpackage

// File: rtl/dmac_cmpl_counter.sv
// Completion counter: counts completion strobes down from a threshold.
// Assumes load has priority over a strobe in the same cycle; a strobe at a
// count of 0 wraps to all ones without a hit.
module dmac_cmpl_counter #(
    parameter int unsigned W       = 8,
    parameter int unsigned RST_VAL = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         evt,
    input  logic [W-1:0] thresh,
    output logic [W-1:0] count,
    output logic         hit
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    // A strobe that takes the count from 1 to 0 is a hit.
    assign hit   = evt && !load && (cnt_q == ONE);
    assign count = cnt_q;

    // Count register: load, reload on hit, or plain decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= W'(RST_VAL);
        else if (load)    cnt_q <= load_val;
        else if (hit)     cnt_q <= thresh;
        else if (evt)     cnt_q <= cnt_q - ONE;
    end

    assert_cnt_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !load && cnt_q > ONE) |=> (cnt_q == W'($past(cnt_q) - ONE)));

    assert_cnt_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cnt_q == $past(thresh)));
endmodule

// File: rtl/dmac_delay_timer.sv
// Delay timer: loaded on completions, counts down on tick enables, holds at
// zero, and flags expiry only on the step from 1 to 0.
// Assumes clear beats load, and load beats tick, in the same cycle.
module dmac_delay_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic         expire
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] tmr_q;

    // Expiry is a tick that reaches zero and is not overridden.
    assign expire = tick && !load && !clr && (tmr_q == ONE);
    assign count  = tmr_q;

    // Timer register: clear, restart, or decrement toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)              tmr_q <= '0;
        else if (load)                  tmr_q <= load_val;
        else if (tick && tmr_q != '0)   tmr_q <= tmr_q - ONE;
    end

    assert_tmr_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && !clr && tmr_q != '0) |=> (tmr_q == W'($past(tmr_q) - ONE)));

    assert_tmr_hold_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !clr && tmr_q == '0) |=> (tmr_q == '0));
endmodule

// File: rtl/dmac_chan_ctl.sv
// DMA channel control/status registers with interrupt coalescing.
// Decodes a 32-bit register bus with same-cycle read data, keeps run/halt/idle
// state and the descriptor pointers, and merges completion-count and delay
// interrupts into one level output. Assumes PTR_W <= 32 and that the bus
// offset fits in ADDR_W bits.
module dmac_chan_ctl
    import dmac_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned PTR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              cmpl_evt,
    input  logic              tick_en,
    input  logic              eng_set_idle,
    output logic              run_flag,
    output logic              idle_flag,
    output logic [PTR_W-1:0]  cur_desc,
    output logic [PTR_W-1:0]  tail_desc,
    output logic              start_req,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(OFF_CUR);
    localparam logic [ADDR_W-1:0] A_TAIL = ADDR_W'(OFF_TAIL);
    localparam logic [31:0] SRST_MASK    = 32'(1) << CB_SRST;
    localparam logic [31:0] TMODE_MASK   = 32'(1) << CB_TAILMODE;
    localparam logic [31:0] CTRL_SRST    = CTRL_INIT | SRST_MASK;

    logic [31:0]        ctrl_q;
    logic               halted_q, idle_q, start_q;
    logic [IRQ_N-1:0]   pend_q, pend_set, pend_clr;
    logic [PTR_W-1:0]   cur_q, tail_q;
    logic [FIELD_W-1:0] cnt_val, tmr_val, cnt_load_val;
    logic               cnt_hit, tmr_expire, cnt_load;
    logic               wr_ctrl, wr_stat, wr_cur, wr_tail, rd_ctrl;
    logic               do_srst, do_start;

    // Address decode and control-write classification.
    always_comb begin
        wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
        wr_stat  = bus_wr && (bus_addr == A_STAT);
        wr_cur   = bus_wr && (bus_addr == A_CUR);
        wr_tail  = bus_wr && (bus_addr == A_TAIL);
        rd_ctrl  = bus_rd && (bus_addr == A_CTRL);
        do_srst  = wr_ctrl && (bus_wdata[CB_SRST] || ctrl_q[CB_SRST]);
        do_start = wr_ctrl && !do_srst && bus_wdata[CB_RUN];
    end

    // Control register: soft reset, plain write with tail mode forced, read clears reset bit.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctrl_q <= CTRL_INIT;
        else if (do_srst)  ctrl_q <= CTRL_SRST;
        else if (wr_ctrl)  ctrl_q <= (bus_wdata & ~SRST_MASK) | TMODE_MASK;
        else if (rd_ctrl)  ctrl_q[CB_SRST] <= 1'b0;
    end

    // Halted and idle flags: start and tail writes beat the engine's set-idle.
    always_ff @(posedge clk) begin
        if (!rst_n || do_srst) begin
            halted_q <= 1'b1;
            idle_q   <= 1'b0;
        end else if (do_start) begin
            halted_q <= 1'b0;
            idle_q   <= 1'b0;
        end else if (wr_tail) begin
            idle_q   <= 1'b0;
        end else if (eng_set_idle) begin
            idle_q   <= 1'b1;
        end
    end

    // Pending interrupt sources and write-one-to-clear mask.
    always_comb begin
        pend_set = '0;
        pend_set[0] = cnt_hit;
        pend_set[1] = tmr_expire;
        pend_clr = wr_stat ? bus_wdata[IRQ_LO +: IRQ_N] : '0;
    end

    // Pending interrupt bits: a new event wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n || do_srst) pend_q <= '0;
        else                   pend_q <= (pend_q & ~pend_clr) | pend_set;
    end

    // Descriptor pointers and the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= '0;
            tail_q  <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= wr_tail;
            if (wr_cur)  cur_q  <= bus_wdata[PTR_W-1:0];
            if (wr_tail) tail_q <= bus_wdata[PTR_W-1:0];
        end
    end

    // Counter reload source: a control write, or a timer expiry.
    always_comb begin
        cnt_load = wr_ctrl || tmr_expire;
        if (do_srst)      cnt_load_val = CTRL_INIT[THR_LO +: FIELD_W];
        else if (wr_ctrl) cnt_load_val = bus_wdata[THR_LO +: FIELD_W];
        else              cnt_load_val = ctrl_q[THR_LO +: FIELD_W];
    end

    dmac_cmpl_counter #(.W(FIELD_W), .RST_VAL(1)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .evt      (cmpl_evt),
        .thresh   (ctrl_q[THR_LO +: FIELD_W]),
        .count    (cnt_val),
        .hit      (cnt_hit)
    );

    dmac_delay_timer #(.W(FIELD_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (do_srst),
        .load     (cmpl_evt && (ctrl_q[DLY_LO +: FIELD_W] != '0)),
        .load_val (ctrl_q[DLY_LO +: FIELD_W]),
        .tick     (tick_en),
        .count    (tmr_val),
        .expire   (tmr_expire)
    );

    // Read-data multiplexer, status assembled with live counters.
    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_q;
            A_STAT:  bus_rdata = {tmr_val, cnt_val, 1'b0, pend_q, 10'b0, idle_q, halted_q};
            A_CUR:   bus_rdata = 32'(cur_q);
            A_TAIL:  bus_rdata = 32'(tail_q);
            default: bus_rdata = '0;
        endcase
    end

    assign run_flag  = ctrl_q[CB_RUN];
    assign idle_flag = idle_q;
    assign cur_desc  = cur_q;
    assign tail_desc = tail_q;
    assign start_req = start_q;
    assign irq       = |(pend_q & ctrl_q[IRQ_LO +: IRQ_N]);

    assert_srst_halts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CTRL && bus_wdata[CB_SRST])
        |=> (halted_q && ctrl_q[CB_SRST] && pend_q == '0 && tmr_val == '0));

    assert_run_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[CB_RUN] && !bus_wdata[CB_SRST] && !ctrl_q[CB_SRST])
        |=> (!halted_q && !idle_q && run_flag));

    assert_hit_sets_ioc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_hit |=> pend_q[0]);

    assert_expire_sets_dly_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_expire |=> pend_q[1]);

    assert_tail_starts_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_TAIL) |=> (start_req && !idle_flag));

    assert_ctrl_write_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !do_srst) |=> (cnt_val == $past(bus_wdata[THR_LO +: FIELD_W])));
endmodule

// File: tb/dmac_chan_ctl_tb_top.sv
module dmac_chan_ctl_tb_top;
    localparam int unsigned ADDR_W = 6;
    localparam int unsigned PTR_W  = 32;
    localparam int unsigned NVEC   = 16;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_EV = 2'd2;

    // {op, offset, write data, expected read data}
    localparam logic [73:0] VEC [NVEC] = '{
        {OP_RD, 8'h00, 32'h0,          32'h0001_0002},  // R1 R2 reset control
        {OP_RD, 8'h04, 32'h0,          32'h0001_0001},  // R1 reset status
        {OP_WR, 8'h00, 32'h0003_1001,  32'h0},          // run, thr 3, ioc enable
        {OP_RD, 8'h00, 32'h0,          32'h0003_1003},  // R2 mode bit forced
        {OP_RD, 8'h04, 32'h0,          32'h0003_0000},  // R4 R5 R10
        {OP_EV, 8'h00, 32'h0,          32'h0},
        {OP_RD, 8'h04, 32'h0,          32'h0002_0000},  // R6 decrement
        {OP_EV, 8'h00, 32'h0,          32'h0},
        {OP_EV, 8'h00, 32'h0,          32'h0},
        {OP_RD, 8'h04, 32'h0,          32'h0003_1000},  // R6 hit and reload
        {OP_WR, 8'h04, 32'h0000_1000,  32'h0},
        {OP_RD, 8'h04, 32'h0,          32'h0003_0000},  // R8 cleared
        {OP_WR, 8'h10, 32'h0000_0080,  32'h0},
        {OP_RD, 8'h10, 32'h0,          32'h0000_0080},  // R11 tail
        {OP_WR, 8'h08, 32'h0000_0040,  32'h0},
        {OP_RD, 8'h08, 32'h0,          32'h0000_0040}   // R11 current
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0, bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              cmpl_evt = 1'b0, tick_en = 1'b0, eng_set_idle = 1'b0;
    logic              run_flag, idle_flag, start_req, irq;
    logic [PTR_W-1:0]  cur_desc, tail_desc;
    logic [31:0]       rd_val;
    int                checks = 0;
    int                errors = 0;
    bit                done = 1'b0;

    always #4 clk = ~clk;

    dmac_chan_ctl #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmpl_evt(cmpl_evt), .tick_en(tick_en), .eng_set_idle(eng_set_idle),
        .run_flag(run_flag), .idle_flag(idle_flag), .cur_desc(cur_desc),
        .tail_desc(tail_desc), .start_req(start_req), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One bus/strobe cycle, entered and left at a falling edge.
    task automatic cyc(input bit wr, input bit rd, input bit ev, input bit tk,
                       input bit si, input logic [7:0] off, input logic [31:0] d);
        bus_wr = wr; bus_rd = rd; cmpl_evt = ev; tick_en = tk; eng_set_idle = si;
        bus_addr = off[ADDR_W-1:0]; bus_wdata = d;
        #2 rd_val = bus_rdata;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; cmpl_evt = 0; tick_en = 0; eng_set_idle = 0;
    endtask

    task automatic wr(input logic [7:0] off, input logic [31:0] d);
        cyc(1, 0, 0, 0, 0, off, d);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] off, input logic [31:0] exp);
        cyc(0, 1, 0, 0, 0, off, 32'h0);
        check(req, rd_val, exp);
    endtask

    task automatic ev();
        cyc(0, 0, 1, 0, 0, 8'h00, 32'h0);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 1, 0, 8'h00, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq after reset", 32'(irq), 32'h0);
        check("R1 start_req after reset", 32'(start_req), 32'h0);

        for (int v = 0; v < NVEC; v++) begin
            logic [73:0] e;
            e = VEC[v];
            case (e[73:72])
                OP_WR: wr(e[71:64], e[63:32]);
                OP_RD: rd_chk($sformatf("table %0d R1/R2/R4/R6/R8/R10/R11", v), e[71:64], e[31:0]);
                default: ev();
            endcase
        end

        // R9: interrupt follows pending AND enable.
        ev(); ev(); ev();
        check("R9 irq with ioc enabled", 32'(irq), 32'h1);
        wr(8'h00, 32'h0003_0001);
        check("R9 irq masked", 32'(irq), 32'h0);
        rd_chk("R5 R9 pending kept, counter reloaded", 8'h04, 32'h0003_1000);
        wr(8'h04, 32'h0000_1000);
        rd_chk("R8 ioc cleared", 8'h04, 32'h0003_0000);

        // R7: delay timer.
        wr(8'h00, 32'h0505_2001);
        ev();
        rd_chk("R7 timer loaded", 8'h04, 32'h0504_0000);
        tick(4);
        rd_chk("R7 timer counting", 8'h04, 32'h0104_0000);
        tick(1);
        check("R7 R9 delay irq", 32'(irq), 32'h1);
        rd_chk("R7 expiry reloads counter", 8'h04, 32'h0005_2000);
        tick(3);
        rd_chk("R7 timer holds at zero", 8'h04, 32'h0005_2000);
        wr(8'h04, 32'h0000_2000);
        check("R8 R9 delay irq cleared", 32'(irq), 32'h0);
        ev(); tick(2);
        rd_chk("R7 partial countdown", 8'h04, 32'h0304_0000);
        ev();
        rd_chk("R7 restart on completion", 8'h04, 32'h0503_0000);

        // R3: soft reset and its pending bit.
        wr(8'h00, 32'h0000_0004);
        wr(8'h00, 32'h0002_0001);
        rd_chk("R3 status after soft reset", 8'h04, 32'h0001_0001);
        check("R3 run blocked while pending", 32'(run_flag), 32'h0);
        rd_chk("R3 reset bit visible", 8'h00, 32'h0001_0006);
        rd_chk("R3 reset bit cleared by read", 8'h00, 32'h0001_0002);

        // R4 and R13: run with zero threshold.
        wr(8'h00, 32'h0000_0001);
        check("R4 run_flag", 32'(run_flag), 32'h1);
        rd_chk("R4 halted cleared", 8'h04, 32'h0000_0000);
        ev();
        rd_chk("R13 counter wraps, no irq", 8'h04, 32'h00FF_0000);

        // R12 and R11: engine idle and tail write.
        cyc(0, 0, 0, 0, 1, 8'h00, 32'h0);
        check("R12 idle_flag set", 32'(idle_flag), 32'h1);
        rd_chk("R12 idle in status", 8'h04, 32'h00FF_0002);
        cyc(1, 0, 0, 0, 1, 8'h10, 32'h0000_0100);
        check("R11 start pulse", 32'(start_req), 32'h1);
        check("R12 tail write beats set-idle", 32'(idle_flag), 32'h0);
        check("R11 tail_desc port", tail_desc, 32'h0000_0100);
        @(negedge clk);
        check("R11 start pulse one cycle", 32'(start_req), 32'h0);

        // R1: hardware reset again.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_chk("R1 control", 8'h00, 32'h0001_0002);
        rd_chk("R1 status", 8'h04, 32'h0001_0001);
        rd_chk("R1 current pointer", 8'h08, 32'h0);
        rd_chk("R1 tail pointer", 8'h10, 32'h0);
        check("R1 cur_desc port", cur_desc, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule